// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one output-compare channel together with the small up-counter that drives it. The counter runs from zero to a programmable reload value, wraps to zero and, on the cycle of the wrap, signals an update event. Each counting cycle the channel compares the counter with its active compare value. On a hit, the channel moves an internal active-high reference signal according to a 3-bit mode: it can leave the reference alone, set it, clear it or toggle it. Two further mode codes hold the reference low or high whatever the comparison gives. The comparison and its flag keep running in those two modes.

The pin output is the reference, or its inverse when the polarity bit is set. The pin is held at 0 while the output-enable bit is clear. The compare value is written either straight into the active register or into a preload register that is copied across on the next update event. A hit sets a sticky flag, which software clears by writing 1 to it. A level interrupt follows the flag when the mask bit allows it. All configuration goes through a single-cycle write port with a 3-bit address.

Top module: `compareChannel`

## Requirements
- R1: After reset the count, reference, pin output, flag, interrupt and update event are all 0, and the reload value is all ones. While the count-enable bit (control bit 0) is set, the count rises by one per clock. When the count equals the reload value, the update event is high for that cycle and the next count is 0. While count-enable is clear, the count holds. Register addresses: 0 control, 1 reload, 2 compare, 3 flag clear, 4 count load.
- R2: A match is a counting cycle in which the count equals the active compare value. Effects of a match show one clock later.
- R3: Mode code 0 (control bits 4:2) leaves the reference unchanged on a match.
- R4: Mode code 1 sets the reference to 1 on a match, and mode code 2 clears it to 0.
- R5: Mode code 3 inverts the reference on every match.
- R6: Mode code 4 holds the reference at 0 and mode code 5 holds it at 1, starting the clock after the mode is loaded. Matches still set the flag in these modes.
- R7: With the polarity bit (control bit 5) at 0 the pin output equals the reference. With it at 1 the pin output is the inverse of the reference.
- R8: With output-enable (control bit 6) at 0 the pin output is 0, and the reference keeps following the mode.
- R9: With the buffer bit (control bit 1) at 0, a write to the compare address is used from the next clock on.
- R10: With the buffer bit at 1, a write to the compare address goes into a preload register. It becomes the active compare value only at the clock that ends an update-event cycle.
- R11: The update event never changes the reference or the pin output.
- R12: A match sets the flag, and the flag stays set until a write to address 3 with data bit 0 at 1. A write with bit 0 at 0 has no effect. When a match and a clearing write fall on the same clock, the flag ends up set.
- R13: The interrupt output is high exactly when the flag is set and the mask bit (control bit 7) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| ocRef | output | 1 | Active-high reference waveform |
| ocOut | output | 1 | Pin output after polarity and enable |
| matchFlag | output | 1 | Sticky match flag |
| irq | output | 1 | Masked interrupt request |
| updateEvt | output | 1 | High in the cycle the counter wraps |

## Verification
The bench runs each mode through a table of runs that differ in reload, compare value and length. It works out from R1 and R2 how many matches fall in each run and predicts the reference, pin, flag and count from that. A toggle that fired twice, or a forced mode that stopped the flag, would show up as a wrong level or a missing flag. A directed buffer test writes a new compare value part-way through a period. A channel that ignores the buffer bit would toggle at the new value before the wrap. A channel that moves the reference on the update event would change level at the wrap. Further directed tests put a flag clear on the same clock as a match, where a design that favours the clear would drop the flag, and check that the mask and the clear write's bit 0 are both respected.

// File: rtl/ocPkg.sv
package ocPkg;

  localparam int ADDR_W      = 3;
  localparam int CTRL_W      = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd4;

  // Reference behaviour selected by the mode field.
  typedef enum logic [2:0] {
    MODE_FROZEN   = 3'd0,
    MODE_SET      = 3'd1,
    MODE_CLR      = 3'd2,
    MODE_TOGGLE   = 3'd3,
    MODE_FORCE_LO = 3'd4,
    MODE_FORCE_HI = 3'd5
  } ocModeE;

  // Control register, bit 7 down to bit 0.
  typedef struct packed {
    logic   irqMask;
    logic   outEn;
    logic   polarity;
    ocModeE mode;
    logic   bufEn;
    logic   cntEn;
  } ctrlRegT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic run;
    logic reloadWr;
    logic cmpWr;
    logic cntWr;
    logic bufEn;
  } dpStrobeT;

endpackage

// File: rtl/ocDatapath.sv
module ocDatapath
  import ocPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             matchHit,
  output logic             wrapHit
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] reloadQ;
  logic [CNT_W-1:0] preloadQ;
  logic [CNT_W-1:0] activeQ;

  assign wrapHit  = strobe.run && (countQ == reloadQ);
  assign matchHit = strobe.run && (countQ == activeQ);
  assign count    = countQ;

  // Counter: a load from the write port wins over counting.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.cntWr) begin
      countQ <= wrData;
    end else if (strobe.run) begin
      countQ <= wrapHit ? '0 : countQ + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '1;
    end else if (strobe.reloadWr) begin
      reloadQ <= wrData;
    end
  end

  // Compare path: direct write, or preload copied on the update event.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preloadQ <= '0;
      activeQ  <= '0;
    end else begin
      if (strobe.cmpWr) begin
        preloadQ <= wrData;
        if (!strobe.bufEn) activeQ <= wrData;
      end
      if (strobe.bufEn && wrapHit) begin
        activeQ <= preloadQ;
      end
    end
  end

endmodule

// File: rtl/ocControl.sv
module ocControl
  import ocPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTRL_W-1:0] ctlData,
  input  logic              matchHit,
  output dpStrobeT          strobe,
  output ctrlRegT           ctrlQ,
  output logic              ocRef,
  output logic              matchFlag
);

  logic ctrlWr;
  logic clearHit;
  logic refQ;
  logic flagQ;

  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign clearHit = wrEn && (wrAddr == ADDR_FLAG) && ctlData[0];

  always_comb begin
    strobe.run      = ctrlQ.cntEn;
    strobe.reloadWr = wrEn && (wrAddr == ADDR_RELOAD);
    strobe.cmpWr    = wrEn && (wrAddr == ADDR_CMP);
    strobe.cntWr    = wrEn && (wrAddr == ADDR_COUNT);
    strobe.bufEn    = ctrlQ.bufEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= ctrlRegT'(ctlData);
    end
  end

  // Reference level: forced modes override, others act only on a match.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ <= 1'b0;
    end else begin
      case (ctrlQ.mode)
        MODE_FORCE_LO: refQ <= 1'b0;
        MODE_FORCE_HI: refQ <= 1'b1;
        MODE_SET:      if (matchHit) refQ <= 1'b1;
        MODE_CLR:      if (matchHit) refQ <= 1'b0;
        MODE_TOGGLE:   if (matchHit) refQ <= ~refQ;
        default:       refQ <= refQ;
      endcase
    end
  end

  // Sticky flag: a new match wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (matchHit) begin
      flagQ <= 1'b1;
    end else if (clearHit) begin
      flagQ <= 1'b0;
    end
  end

  assign ocRef     = refQ;
  assign matchFlag = flagQ;

endmodule

// File: rtl/compareChannel.sv
module compareChannel
  import ocPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  count,
  output logic              ocRef,
  output logic              ocOut,
  output logic              matchFlag,
  output logic              irq,
  output logic              updateEvt
);

  dpStrobeT strobe;
  ctrlRegT  ctrlQ;
  logic     matchHit;
  logic     wrapHit;

  ocControl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .ctlData   (wrData[CTRL_W-1:0]),
    .matchHit  (matchHit),
    .strobe    (strobe),
    .ctrlQ     (ctrlQ),
    .ocRef     (ocRef),
    .matchFlag (matchFlag)
  );

  ocDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .count    (count),
    .matchHit (matchHit),
    .wrapHit  (wrapHit)
  );

  assign ocOut     = ctrlQ.outEn & (ocRef ^ ctrlQ.polarity);
  assign irq       = matchFlag & ctrlQ.irqMask;
  assign updateEvt = wrapHit;

endmodule

// File: rtl/compareChannelChecker.sv
module compareChannelChecker
  import ocPkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CNT_W-1:0]  count,
  input logic              ocRef,
  input logic              ocOut,
  input logic              matchFlag,
  input logic              irq,
  input logic              updateEvt,
  input ctrlRegT           ctrlQ,
  input logic              matchHit
);

  logic cntLoad;
  logic flagClr;
  assign cntLoad = wrEn && (wrAddr == ADDR_COUNT);
  assign flagClr = wrEn && (wrAddr == ADDR_FLAG);

  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    updateEvt && !cntLoad |=> count == '0);

  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.cntEn && !cntLoad |=> $stable(count));

  p_force_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ.mode == MODE_FORCE_LO |=> !ocRef);

  p_force_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ.mode == MODE_FORCE_HI |=> ocRef);

  p_pin_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.outEn |-> !ocOut);

  p_ref_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !matchHit && ctrlQ.mode != MODE_FORCE_LO && ctrlQ.mode != MODE_FORCE_HI
    |=> $stable(ocRef));

  p_flag_set_r12: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> matchFlag);

  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    matchFlag && !flagClr |=> matchFlag);

  p_irq_masked_r13: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.irqMask |-> !irq);

endmodule

bind compareChannel compareChannelChecker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .count     (count),
  .ocRef     (ocRef),
  .ocOut     (ocOut),
  .matchFlag (matchFlag),
  .irq       (irq),
  .updateEvt (updateEvt),
  .ctrlQ     (ctrlQ),
  .matchHit  (matchHit)
);

// File: tb/compareChannel_test.sv
`timescale 1ns/1ps
module compareChannel_test;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [2:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic [CNT_W-1:0] count;
  logic             ocRef, ocOut, matchFlag, irq, updateEvt;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  compareChannel #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .ocRef(ocRef), .ocOut(ocOut), .matchFlag(matchFlag),
    .irq(irq), .updateEvt(updateEvt)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic       init;
    logic       pol;
    logic       oe;
    logic       mask;
    logic [7:0] rel;
    logic [7:0] cmp;
    logic [7:0] w;
  } vecT;

  localparam int NV = 9;
  localparam vecT VECS [NV] = '{
    '{3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd9, 8'd3, 8'd5},
    '{3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'd9, 8'd3, 8'd5},
    '{3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd9, 8'd3, 8'd5},
    '{3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'd4, 8'd2, 8'd9},
    '{3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 8'd4, 8'd2, 8'd4},
    '{3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 8'd9, 8'd3, 8'd5},
    '{3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 8'd9, 8'd3, 8'd5},
    '{3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd9, 8'd8, 8'd5},
    '{3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 8'd9, 8'd8, 8'd5}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the following posedge.
  task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [CNT_W-1:0] ctl(input logic [2:0] mode, input logic bufEn,
      input logic run, input logic pol, input logic oe, input logic mask);
    return CNT_W'({mask, oe, pol, mode, bufEn, run});
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state (R1)
    check("R1 reset count", count, 0);
    check("R1 reset ref", ocRef, 0);
    check("R1 reset out", ocOut, 0);
    check("R1 reset flag", matchFlag, 0);
    check("R1 reset irq", irq, 0);
    check("R1 reset update", updateEvt, 0);

    // Table: modes, polarity, enable, flag, immediate compare (R2-R9, R12, R13)
    for (int i = 0; i < NV; i++) begin
      automatic vecT v = VECS[i];
      automatic int  hits = 0;
      automatic logic expRef;
      automatic logic expFlag;
      wr(3'd0, ctl(v.init ? 3'd5 : 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
      wr(3'd1, CNT_W'(v.rel));
      wr(3'd2, CNT_W'(v.cmp));
      wr(3'd4, '0);
      wr(3'd3, CNT_W'(1));
      wr(3'd0, ctl(v.mode, 1'b0, 1'b1, v.pol, v.oe, v.mask));
      repeat (int'(v.w)) @(negedge clk);
      wr(3'd0, ctl(v.mode, 1'b0, 1'b0, v.pol, v.oe, v.mask));
      for (int k = 1; k <= int'(v.w) + 1; k++)
        if ((k - 1) % (int'(v.rel) + 1) == int'(v.cmp)) hits++;
      case (v.mode)
        3'd1:    expRef = (hits > 0) ? 1'b1 : v.init;
        3'd2:    expRef = (hits > 0) ? 1'b0 : v.init;
        3'd3:    expRef = v.init ^ hits[0];
        3'd4:    expRef = 1'b0;
        3'd5:    expRef = 1'b1;
        default: expRef = v.init;
      endcase
      expFlag = (hits > 0);
      check($sformatf("R3 R4 R5 R6 R9 ref vec%0d", i), ocRef, expRef);
      check($sformatf("R7 R8 out vec%0d", i), ocOut, v.oe & (expRef ^ v.pol));
      check($sformatf("R2 R6 R12 flag vec%0d", i), matchFlag, expFlag);
      check($sformatf("R13 irq vec%0d", i), irq, expFlag & v.mask);
      check($sformatf("R1 count vec%0d", i), count, (int'(v.w) + 1) % (int'(v.rel) + 1));
    end

    // Counting, wrap and update event (R1)
    wr(3'd1, CNT_W'(3));
    wr(3'd4, '0);
    wr(3'd0, ctl(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    check("R1 count start", count, 0);
    check("R1 no update", updateEvt, 0);
    for (int k = 2; k <= 5; k++) begin
      @(negedge clk);
      check("R1 count step", count, (k - 1) % 4);
      check("R1 update pulse", updateEvt, (k == 4));
    end
    wr(3'd0, ctl(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R1 last run edge", count, 1);
    repeat (3) @(negedge clk);
    check("R1 hold when stopped", count, 1);

    // Preload buffer and update-event neutrality (R10, R11)
    wr(3'd0, ctl(3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    wr(3'd1, CNT_W'(9));
    wr(3'd2, CNT_W'(2));
    wr(3'd4, '0);
    wr(3'd0, ctl(3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    wr(3'd2, CNT_W'(5));
    wr(3'd0, ctl(3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
    check("R10 ref before match", ocRef, 0);
    for (int k = 2; k <= 17; k++) begin
      @(negedge clk);
      if (k == 4)  check("R10 old compare used", ocRef, 1);
      if (k == 10) check("R10 update pulse", updateEvt, 1);
      if (k == 10) check("R10 no match on new value early", ocRef, 1);
      if (k == 11) check("R11 ref after update", ocRef, 1);
      if (k == 11) check("R11 out after update", ocOut, 1);
      if (k == 17) check("R10 new compare after update", ocRef, 0);
    end
    wr(3'd0, ctl(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));

    // Flag set-wins, write-1-to-clear and interrupt mask (R12, R13)
    wr(3'd2, CNT_W'(3));
    wr(3'd1, CNT_W'(9));
    wr(3'd4, '0);
    wr(3'd3, CNT_W'(1));
    check("R12 flag cleared", matchFlag, 0);
    wr(3'd0, ctl(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    wr(3'd3, CNT_W'(1));
    check("R12 set wins over clear", matchFlag, 1);
    wr(3'd3, CNT_W'(1));
    check("R12 clear by write one", matchFlag, 0);
    repeat (10) @(negedge clk);
    check("R12 flag set again", matchFlag, 1);
    check("R13 irq masked off", irq, 0);
    wr(3'd0, ctl(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
    check("R13 irq with mask", irq, 1);
    wr(3'd3, CNT_W'(0));
    check("R12 write zero ignored", matchFlag, 1);
    wr(3'd3, CNT_W'(1));
    check("R12 cleared", matchFlag, 0);
    check("R13 irq follows flag", irq, 0);
    wr(3'd0, ctl(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule